// File: doc/BRIEF.md
# Three-Mode Down-Counting Timer with Edge Capture

A 16-bit down-counter paired with two 16-bit holding registers (reload/capture A and B) and two input pins. A three-bit mode code in the control word picks one of three behaviours.

- **Self-running PWM.** The counter reloads alternately from the two holding registers, and can toggle an output pin on every reload.
- **Event counter.** The counter steps down once per rising edge on pin A.
- **Capture.** The counter steps down on the instruction-rate tick, and chosen edges on pin A or pin B copy the live count into holding register A or B.

Two interrupt channels each have a pending flag and an enable flag. A start/stop bit runs the counter in the first two modes and becomes the underflow flag in capture mode.

Software reaches every register through a small synchronous write / combinational read bus. Both pins pass through a two-flop synchroniser and a one-cycle edge detector before any logic sees them.

Top module: `modal_timer`

## Requirements
- R1: After reset the counter, both holding registers and the control word read as 0, and `pinAOut`, `irqA` and `irqB` are low.
- R2: Bus address 0 is the counter, 1 is holding register A, and 2 is holding register B. Address 3 is the control word: bit0 run/underflow flag, bit1 pending A, bit2 enable A, bit3 pending B, bit4 enable B, bit5 mode C1, bit6 mode C2, bit7 mode C3. A write takes effect at the next clock edge, and reads return the stored values.
- R3: In PWM mode (C2=0, C3=1), with run=1, each tick decrements a nonzero count. A tick at count 0 reloads instead of decrementing. Reloads alternate, with holding register A first after reset. An A reload sets pending A, and a B reload sets pending B.
- R4: Mode code {C3,C2,C1}=101 inverts `pinAOut` on every PWM reload. Code 100 leaves it unchanged.
- R5: In PWM and event-counter modes, run=0 holds the counter.
- R6: Codes 000 and 001 count down once per synchronised rising edge of pin A (the tick is ignored). A step from 0 wraps to 0xFFFF and sets pending A. Every rising edge of pin B sets pending B.
- R7: In capture mode (C2=1), the counter decrements on every tick regardless of bit0. A tick at 0 wraps to 0xFFFF and sets both bit0 and pending A.
- R8: In capture mode, C1 selects the pin A edge and C3 selects the pin B edge (0 = rising, 1 = falling). A selected edge copies the counter value held before that cycle's step into holding register A or B and sets the matching pending flag. An unselected edge changes nothing.
- R9: `irqA` is high exactly while pending A and enable A are both 1; `irqB` likewise with pending B and enable B.
- R10: Writing 0 clears a flag. When a hardware set and a software write of 0 fall in the same cycle, the flag ends up set.
- R11: A pin level first sampled at clock edge k acts at edge k+2.
- R12: A bus write to the counter overrides that cycle's step or reload. A capture overrides a bus write to the same holding register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Instruction-rate count enable |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| pinA | input | 1 | External pin A (asynchronous) |
| pinB | input | 1 | External pin B (asynchronous) |
| pinAOut | output | 1 | PWM toggle output |
| irqA | output | 1 | Interrupt channel A |
| irqB | output | 1 | Interrupt channel B |

## Verification
The bench targets these corner cases and the failure each one would expose:

- **Underflow beside a software clear.** An underflow lands in the same cycle as a software write that clears the pending flags. A design where the clear wins would lose the interrupt.
- **Reload alternation.** A wrong start phase would swap the A and B periods and their flags.
- **Pin latency.** Pin edges are timed to the exact edge of action, so a missing or extra synchroniser stage shifts every count by one.
- **Edge polarity.** Every capture code is exercised, along with deliberately unselected edges. Swapped edge selects would capture on the wrong transition.
- **Bus collisions.** A long mixed phase collides bus writes with steps, reloads and captures, which exposes any wrong write priority.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;
  typedef struct packed {
    logic step;   // decrement by one
    logic loadA;  // reload from holding register A
    logic loadB;  // reload from holding register B
    logic capA;   // copy count into holding register A
    logic capB;   // copy count into holding register B
  } tmrStrobe_t;

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_HOLD_A = 2'd1,
    ADDR_HOLD_B = 2'd2,
    ADDR_CTRL  = 2'd3
  } tmrAddr_t;

  localparam int CTL_W       = 8;
  localparam int CTL_RUN     = 0;
  localparam int CTL_PEND_A  = 1;
  localparam int CTL_EN_A    = 2;
  localparam int CTL_PEND_B  = 3;
  localparam int CTL_EN_B    = 4;
  localparam int CTL_SEL_A   = 5;
  localparam int CTL_CAPMODE = 6;
  localparam int CTL_SEL_B   = 7;
endpackage

// File: rtl/modal_timer_sync.sv
module modal_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/modal_timer_dp.sv
module modal_timer_dp
  import modal_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic             wrCount,
  input  logic             wrHoldA,
  input  logic             wrHoldB,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] holdA,
  output logic [CNT_W-1:0] holdB,
  output logic             cntZero
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (wrCount) begin
      countVal <= wdata;
    end else if (stb.loadA) begin
      countVal <= holdA;
    end else if (stb.loadB) begin
      countVal <= holdB;
    end else if (stb.step) begin
      countVal <= countVal - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdA <= '0;
      holdB <= '0;
    end else begin
      if (stb.capA)     holdA <= countVal;
      else if (wrHoldA) holdA <= wdata;
      if (stb.capB)     holdB <= countVal;
      else if (wrHoldB) holdB <= wdata;
    end
  end

  assign cntZero = (countVal == '0);
endmodule

// File: rtl/modal_timer_ctrl.sv
module modal_timer_ctrl
  import modal_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pinA,
  input  logic             pinB,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlWdata,
  input  logic             cntZero,
  output tmrStrobe_t       stb,
  output logic [CTL_W-1:0] ctlWord,
  output logic             pinAOut,
  output logic             irqA,
  output logic             irqB
);
  logic [1:0] pinVec, riseVec, fallVec;
  assign pinVec = {pinB, pinA};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    modal_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (pinVec[i]),
      .rise(riseVec[i]),
      .fall(fallVec[i])
    );
  end

  logic run, pendA, enA, pendB, enB, selA, capMode, selB;
  logic phaseB, toggleOut;
  logic pwmMode, evtMode, edgeA, edgeB, doStep, underflow, setA, setB;

  always_comb begin
    pwmMode   = !capMode && selB;
    evtMode   = !capMode && !selB;
    edgeA     = selA ? fallVec[0] : riseVec[0];
    edgeB     = selB ? fallVec[1] : riseVec[1];
    doStep    = pwmMode ? (run && tickEn)
              : evtMode ? (run && riseVec[0]) : tickEn;
    underflow = doStep && cntZero;
    stb.loadA = pwmMode && underflow && !phaseB;
    stb.loadB = pwmMode && underflow && phaseB;
    stb.step  = doStep && !(pwmMode && cntZero);
    stb.capA  = capMode && edgeA;
    stb.capB  = capMode && edgeB;
    setA      = stb.loadA || (evtMode && underflow) || (capMode && (underflow || edgeA));
    setB      = stb.loadB || (evtMode && riseVec[1]) || stb.capB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {selB, capMode, selA, enB, pendB, enA, pendA, run} <= '0;
      phaseB    <= 1'b0;
      toggleOut <= 1'b0;
    end else begin
      if (ctlWe) begin
        run     <= ctlWdata[CTL_RUN];
        pendA   <= ctlWdata[CTL_PEND_A];
        enA     <= ctlWdata[CTL_EN_A];
        pendB   <= ctlWdata[CTL_PEND_B];
        enB     <= ctlWdata[CTL_EN_B];
        selA    <= ctlWdata[CTL_SEL_A];
        capMode <= ctlWdata[CTL_CAPMODE];
        selB    <= ctlWdata[CTL_SEL_B];
      end
      if (capMode && underflow) run <= 1'b1;
      if (setA) pendA <= 1'b1;
      if (setB) pendB <= 1'b1;
      if (pwmMode && underflow) begin
        phaseB <= ~phaseB;
        if (selA) toggleOut <= ~toggleOut;
      end
    end
  end

  assign ctlWord = {selB, capMode, selA, enB, pendB, enA, pendA, run};
  assign pinAOut = toggleOut;
  assign irqA    = pendA && enA;
  assign irqB    = pendB && enB;
endmodule

// File: rtl/modal_timer.sv
module modal_timer
  import modal_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic             pinA,
  input  logic             pinB,
  output logic             pinAOut,
  output logic             irqA,
  output logic             irqB
);
  tmrStrobe_t       stb;
  logic [CTL_W-1:0] ctlWord;
  logic [CNT_W-1:0] countVal, holdA, holdB;
  logic             cntZero;

  modal_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pinA(pinA), .pinB(pinB),
    .ctlWe(busWe && busAddr == ADDR_CTRL), .ctlWdata(busWdata[CTL_W-1:0]),
    .cntZero(cntZero), .stb(stb), .ctlWord(ctlWord),
    .pinAOut(pinAOut), .irqA(irqA), .irqB(irqB)
  );

  modal_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrCount(busWe && busAddr == ADDR_COUNT),
    .wrHoldA(busWe && busAddr == ADDR_HOLD_A),
    .wrHoldB(busWe && busAddr == ADDR_HOLD_B),
    .wdata(busWdata), .countVal(countVal), .holdA(holdA), .holdB(holdB),
    .cntZero(cntZero)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_COUNT:  busRdata = countVal;
      ADDR_HOLD_A: busRdata = holdA;
      ADDR_HOLD_B: busRdata = holdB;
      default:     busRdata = {{(CNT_W-CTL_W){1'b0}}, ctlWord};
    endcase
  end
endmodule

// File: rtl/modal_timer_chk.sv
module modal_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             busWe,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] holdA,
  input logic [CNT_W-1:0] holdB,
  input logic [7:0]       ctlWord,
  input logic             pinAOut,
  input logic             irqA,
  input logic             irqB
);
  logic cntWr, pwmOn, capOn;
  assign cntWr = busWe && (busAddr == 2'd0);
  assign pwmOn = !ctlWord[6] && ctlWord[7];
  assign capOn = ctlWord[6];

  p_pwm_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOn && ctlWord[0] && tickEn && countVal == '0 && !cntWr)
      |=> ((countVal == $past(holdA) || countVal == $past(holdB)) && (ctlWord[1] || ctlWord[3])));

  p_no_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWord[7:5] == 3'b100) |=> $stable(pinAOut));

  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!capOn && !ctlWord[0] && !cntWr) |=> $stable(countVal));

  p_cap_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capOn && tickEn && countVal != '0 && !cntWr)
      |=> (countVal == CNT_W'($past(countVal) - 1'b1)));

  p_uf_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (capOn && tickEn && countVal == '0 && !cntWr) |=> (ctlWord[0] && ctlWord[1]));

  p_irq_a_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqA |-> (ctlWord[1] && ctlWord[2]));

  p_irq_b_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqB |-> (ctlWord[3] && ctlWord[4]));
endmodule

bind modal_timer modal_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe), .busAddr(busAddr),
  .countVal(countVal), .holdA(holdA), .holdB(holdB), .ctlWord(ctlWord),
  .pinAOut(pinAOut), .irqA(irqA), .irqB(irqB)
);

// File: tb/modal_timer_tb.sv
module modal_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, pinA = 1'b0, pinB = 1'b0, busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [W-1:0] busWdata = '0;
  logic [W-1:0] busRdata;
  logic pinAOut, irqA, irqB;

  always #(CLK_PERIOD/2) clk = ~clk;

  modal_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinA(pinA), .pinB(pinB),
    .pinAOut(pinAOut), .irqA(irqA), .irqB(irqB)
  );

  int nCmp = 0, nBad = 0, cycN = 0, tickDiv = 1;
  string curReq = "R1";
  bit live = 1'b0;

  // behavioural reference state
  logic [W-1:0] mCnt, mRa, mRb, nCnt, nRa, nRb;
  logic mRun, mPendA, mEnA, mPendB, mEnB, mC1, mC2, mC3, mPh, mOut;
  logic [1:0] mDlyA, mDlyB;
  logic mPrevA, mPrevB;
  logic tRiseA, tFallA, tRiseB, tFallB, tPwm, tEvt, tEdgeA, tEdgeB, tStep, tUf, tSetA, tSetB;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = '0; mRa = '0; mRb = '0;
      {mRun, mPendA, mEnA, mPendB, mEnB, mC1, mC2, mC3, mPh, mOut} = '0;
      mDlyA = '0; mDlyB = '0; mPrevA = 1'b0; mPrevB = 1'b0;
    end else begin
      tRiseA = mDlyA[1] && !mPrevA;  tFallA = !mDlyA[1] && mPrevA;
      tRiseB = mDlyB[1] && !mPrevB;  tFallB = !mDlyB[1] && mPrevB;
      tPwm   = !mC2 && mC3;
      tEvt   = !mC2 && !mC3;
      tEdgeA = mC1 ? tFallA : tRiseA;
      tEdgeB = mC3 ? tFallB : tRiseB;
      tStep  = tPwm ? (mRun && tickEn) : (tEvt ? (mRun && tRiseA) : tickEn);
      tUf    = tStep && (mCnt == 0);
      tSetA  = (tPwm && tUf && !mPh) || (tEvt && tUf) || (mC2 && (tUf || tEdgeA));
      tSetB  = (tPwm && tUf && mPh) || (tEvt && tRiseB) || (mC2 && tEdgeB);
      if (busWe && busAddr == 2'd0) nCnt = busWdata;
      else if (tPwm && tUf)         nCnt = mPh ? mRb : mRa;
      else if (tStep)               nCnt = mCnt - 16'd1;
      else                          nCnt = mCnt;
      nRa = (mC2 && tEdgeA) ? mCnt : ((busWe && busAddr == 2'd1) ? busWdata : mRa);
      nRb = (mC2 && tEdgeB) ? mCnt : ((busWe && busAddr == 2'd2) ? busWdata : mRb);
      if (tPwm && tUf) begin
        if (mC1) mOut = !mOut;
        mPh = !mPh;
      end
      if (busWe && busAddr == 2'd3)
        {mC3, mC2, mC1, mEnB, mPendB, mEnA, mPendA, mRun} = busWdata[7:0];
      if (tSetA) mPendA = 1'b1;
      if (tSetB) mPendB = 1'b1;
      if (tStep && tUf && !tPwm && !tEvt) mRun = 1'b1;
      mCnt = nCnt; mRa = nRa; mRb = nRb;
      mPrevA = mDlyA[1]; mDlyA = {mDlyA[0], pinA};
      mPrevB = mDlyB[1]; mDlyB = {mDlyB[0], pinB};
    end
  end

  function automatic logic [W-1:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mCnt;
      2'd1: return mRa;
      2'd2: return mRb;
      default: return {8'd0, mC3, mC2, mC1, mEnB, mPendB, mEnA, mPendA, mRun};
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check(curReq, "busRdata", busRdata, modelRead(busAddr));
      check("R9", "irqA", {15'd0, irqA}, {15'd0, mPendA && mEnA});
      check("R9", "irqB", {15'd0, irqB}, {15'd0, mPendB && mEnB});
      check("R4", "pinAOut", {15'd0, pinAOut}, {15'd0, mOut});
    end
  end

  function automatic logic genTick();
    if (tickDiv == 0) return 1'b0;
    return (cycN % tickDiv) == 0;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      busWe = 1'b0; busAddr = busAddr + 2'd1; tickEn = genTick(); cycN++;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d; tickEn = genTick(); cycN++;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    @(negedge clk); #1;
    busWe = 1'b0; busAddr = a; tickEn = genTick(); cycN++;
    #3;
    check(req, "read", busRdata, exp);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    live = 1'b1;
    // R1 reset state
    curReq = "R1";
    rdChk("R1", 2'd0, 16'h0000);
    rdChk("R1", 2'd1, 16'h0000);
    rdChk("R1", 2'd2, 16'h0000);
    rdChk("R1", 2'd3, 16'h0000);
    check("R1", "irqA", {15'd0, irqA}, 16'd0);
    // R2 register map
    curReq = "R2";
    wr(2'd1, 16'h1234); wr(2'd2, 16'h5678); wr(2'd0, 16'h0abc); wr(2'd3, 16'h0014);
    rdChk("R2", 2'd0, 16'h0abc);
    rdChk("R2", 2'd1, 16'h1234);
    rdChk("R2", 2'd2, 16'h5678);
    rdChk("R2", 2'd3, 16'h0014);
    // R11 synchroniser latency, event mode
    curReq = "R11";
    wr(2'd3, 16'h0015); wr(2'd0, 16'd5); idle(3);
    pinA = 1'b1;
    rdChk("R11", 2'd0, 16'd5);
    rdChk("R11", 2'd0, 16'd5);
    rdChk("R11", 2'd0, 16'd4);
    // R6 event underflow and pin B flag
    curReq = "R6";
    wr(2'd3, 16'h0015); wr(2'd0, 16'd0); pinA = 1'b0; idle(4);
    pinA = 1'b1; idle(2);
    rdChk("R6", 2'd0, 16'hffff);
    rdChk("R6", 2'd3, 16'h0017);
    pinB = 1'b1; idle(3);
    rdChk("R6", 2'd3, 16'h001f);
    check("R9", "irqB", {15'd0, irqB}, 16'd1);
    // R10 underflow set beats software clear
    curReq = "R10";
    tickDiv = 1; pinA = 1'b0; pinB = 1'b0;
    wr(2'd3, 16'h0054); idle(4);
    wr(2'd0, 16'd0); wr(2'd3, 16'h0054);
    rdChk("R10", 2'd3, 16'h0057);
    check("R9", "irqA", {15'd0, irqA}, 16'd1);
    // R8 capture edges, including an unselected edge
    curReq = "R8";
    tickDiv = 0;
    wr(2'd3, 16'h0054); wr(2'd0, 16'h0050); wr(2'd1, 16'h0000); idle(2);
    pinA = 1'b1; idle(2);
    rdChk("R8", 2'd1, 16'h0050);
    wr(2'd3, 16'h00f4); wr(2'd0, 16'h0077); wr(2'd2, 16'h1111);
    pinB = 1'b1; idle(3);
    rdChk("R8", 2'd2, 16'h1111);
    pinB = 1'b0; idle(2);
    rdChk("R8", 2'd2, 16'h0077);
    // R3/R4 PWM with toggle
    curReq = "R3";
    tickDiv = 2; pinA = 1'b0;
    wr(2'd1, 16'd3); wr(2'd2, 16'd1); wr(2'd0, 16'd0); wr(2'd3, 16'h00b5);
    for (int k = 0; k < 4; k++) begin idle(12); wr(2'd3, 16'h00b5); end
    curReq = "R4";
    wr(2'd3, 16'h0095); idle(30);
    // R5 stopped
    curReq = "R5";
    wr(2'd3, 16'h00b4); idle(20);
    // R7/R8 capture sweep over every code
    curReq = "R7";
    tickDiv = 3;
    for (int c = 0; c < 4; c++) begin
      logic [2:0] code;
      code = (c == 0) ? 3'b010 : (c == 1) ? 3'b110 : (c == 2) ? 3'b111 : 3'b011;
      wr(2'd3, {8'd0, code, 5'b10100}); wr(2'd0, 16'd20);
      for (int k = 0; k < 40; k++) begin
        if (k % 5 == 0) pinA = ~pinA;
        if (k % 7 == 0) pinB = ~pinB;
        idle(1);
      end
    end
    // R12 mixed collisions
    curReq = "R12";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      cycN++;
      tickEn   = ($urandom % 3) == 0;
      pinA     = ($urandom % 4) == 0 ? ~pinA : pinA;
      pinB     = ($urandom % 5) == 0 ? ~pinB : pinB;
      busWe    = ($urandom % 6) == 0;
      busAddr  = 2'($urandom % 4);
      busWdata = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 6);
      if (busAddr == 2'd3 && ($urandom % 3) != 0) busWdata[0] = 1'b1;
    end
    idle(4);
    live = 1'b0;
    summary();
    $finish;
  end
endmodule